// File: doc/BRIEF.md
# DDR SDRAM Power-Up Initialization Sequencer

This block is the controller-side state machine that takes DDR SDRAM from power-up to normal operation. A start pulse begins a power-up wait counted in microsecond ticks. The block then issues a fixed chain of commands, each followed by a guard wait: NOP, precharge-all, extended mode register set, mode register set with DLL reset, precharge-all, a run of CBR auto-refreshes, and a final mode register set with DLL reset cleared. It builds the mode-register word that goes on the address bus with each of these commands.

After the last guard wait, the block pulses a resync request to the receive FIFO pointers. It then issues the normal-operation command and raises the refresh-enable and done flags. The refresh-enable flag hands control to an external refresh engine. The block leaves the data path, the pads, SPD reading and periodic refresh to other logic.

Top module: `ddr_init_seq`

## Requirements
- R1: While reset is high, and after it, until a start is accepted: `cmd_stb_o`, `rx_resync_o`, `refresh_en_o` and `done_o` are 0, `cmd_o` is NOP (001) and `mode_word_o` is 0.
- R2: Command codes are 000 self refresh, 001 NOP, 010 precharge all, 011 mode register set, 100 extended mode register set, 110 CBR refresh and 111 normal. Code 101 is never strobed. The strobed order is NOP, precharge, extended MRS, MRS, precharge, CBR refreshes, MRS, normal.
- R3: The first command is strobed in the cycle after the `POWERUP_US`-th tick that is sampled after the start cycle. Ticks sampled during the start cycle are not counted.
- R4: Each later command is strobed in the cycle after the `GUARD_US`-th tick counted from its predecessor's strobe cycle, inclusive. The resync pulse follows the same rule after the final MRS.
- R5: `cmd_stb_o` is high for one cycle per command. `cmd_o` changes only in a strobe cycle and otherwise holds the last issued code.
- R6: The mode word is laid out as follows: bits [2:0] burst length code (default 010, length 4); bit 3 burst type (default 1, interleaved); bits [6:4] the CAS code; bits [8:7] operating mode. The first MRS carries operating mode 10 (DLL reset). The extended MRS word is 0.
- R7: The final MRS carries operating mode 00 with the same burst and CAS fields as the first MRS.
- R8: Exactly `NUM_REF` CBR refreshes are issued between the second precharge and the final MRS (default 8).
- R9: `rx_resync_o` is high for exactly one cycle. It is followed by one cycle with it low, and the normal-command strobe comes in the cycle after that.
- R10: `done_o` and `refresh_en_o` rise together in the cycle after the normal strobe. They stay high until reset.
- R11: A start pulse while a sequence runs or after done has no effect. `cas_sel_i` is captured only in the cycle a start is accepted.
- R12: `mode_word_o` is 0 whenever a command other than an MRS is strobed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start pulse, accepted only when idle |
| cas_sel_i | input | 3 | CAS latency code for mode word bits [6:4] |
| us_tick_i | input | 1 | One-cycle pulse each microsecond |
| cmd_stb_o | output | 1 | One-cycle command strobe |
| cmd_o | output | 3 | Command code |
| mode_word_o | output | MODE_W | Mode-register word for the address bus |
| rx_resync_o | output | 1 | Receive FIFO pointer resync pulse |
| refresh_en_o | output | 1 | Hands over to the external refresh engine |
| done_o | output | 1 | Initialization complete, sticky |

## Verification
A wrong step index shows at once on the next strobe: the command code is out of order, or a mode word appears on the wrong command. A timer that is loaded or decremented wrongly shows as a tick count between strobes that differs from the guard value, which is detectable at the very next strobe. A slip in the tail states shows within three cycles, because the resync pulse, the normal strobe and the done flag have fixed cycle offsets. A CAS value that is not captured at start changes the MRS word, which is seen at the first MRS.

// File: rtl/ddr_init_pkg.sv
package ddr_init_pkg;
  typedef enum logic [2:0] {
    CMD_SELFREF = 3'b000,
    CMD_NOP     = 3'b001,
    CMD_PRE     = 3'b010,
    CMD_MRS     = 3'b011,
    CMD_EMRS    = 3'b100,
    CMD_CBR     = 3'b110,
    CMD_NORMAL  = 3'b111
  } ddr_cmd_e;

  typedef enum logic [2:0] {
    ST_IDLE, ST_WAIT, ST_SYNC, ST_NORM, ST_FIN, ST_DONE
  } init_state_e;

  // Command for a step of the fixed chain; nref refreshes sit at steps 5..4+nref
  function automatic ddr_cmd_e step_cmd(input int unsigned idx, input int unsigned nref);
    if (idx == 0) return CMD_NOP;
    else if (idx == 1 || idx == 4) return CMD_PRE;
    else if (idx == 2) return CMD_EMRS;
    else if (idx == 3) return CMD_MRS;
    else if (idx < 5 + nref) return CMD_CBR;
    else return CMD_MRS;
  endfunction
endpackage

// File: rtl/ddr_init_tick_timer.sv
module ddr_init_tick_timer #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic             tick_i,
  output logic             expire_o
);
  logic [CNT_W-1:0] cnt_q;

  assign expire_o = tick_i && (cnt_q == CNT_W'(1));

  always_ff @(posedge clk) begin
    if (rst) cnt_q <= '0;
    else if (load_i) cnt_q <= load_val_i;
    else if (tick_i && cnt_q != '0) cnt_q <= cnt_q - CNT_W'(1);
  end
endmodule

// File: rtl/ddr_init_mode_word.sv
module ddr_init_mode_word #(
  parameter int unsigned MODE_W  = 13,
  parameter logic [2:0]  BL_CODE = 3'b010,
  parameter logic        BT_BIT  = 1'b1
) (
  input  logic [2:0]        cmd_i,
  input  logic              dll_rst_i,
  input  logic [2:0]        cas_i,
  output logic [MODE_W-1:0] word_o
);
  import ddr_init_pkg::*;
  logic [8:0] core;

  always_comb begin
    core = {(dll_rst_i ? 2'b10 : 2'b00), cas_i, BT_BIT, BL_CODE};
    word_o = '0;
    if (cmd_i == CMD_MRS) word_o[8:0] = core;
  end
endmodule

// File: rtl/ddr_init_seq.sv
module ddr_init_seq #(
  parameter int unsigned POWERUP_US = 200,
  parameter int unsigned GUARD_US   = 200,
  parameter int unsigned NUM_REF    = 8,
  parameter int unsigned MODE_W     = 13,
  parameter logic [2:0]  BL_CODE    = 3'b010,
  parameter logic        BT_BIT     = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic [2:0]        cas_sel_i,
  input  logic              us_tick_i,
  output logic              cmd_stb_o,
  output logic [2:0]        cmd_o,
  output logic [MODE_W-1:0] mode_word_o,
  output logic              rx_resync_o,
  output logic              refresh_en_o,
  output logic              done_o
);
  import ddr_init_pkg::*;

  localparam int unsigned NSTEP   = NUM_REF + 6;
  localparam int unsigned STEP_W  = $clog2(NSTEP + 1);
  localparam int unsigned MAX_US  = (POWERUP_US > GUARD_US) ? POWERUP_US : GUARD_US;
  localparam int unsigned CNT_W   = $clog2(MAX_US + 1);

  init_state_e       state_q;
  logic [STEP_W-1:0] step_q;
  logic [2:0]        cas_q;
  logic              expire;
  logic              load;
  logic [CNT_W-1:0]  load_val;
  logic              more_steps;
  ddr_cmd_e          next_cmd;
  logic [MODE_W-1:0] next_word;

  assign more_steps = (int'(step_q) < NSTEP);
  assign next_cmd   = step_cmd(int'(step_q), NUM_REF);
  assign load       = ((state_q == ST_IDLE) && start_i) ||
                      ((state_q == ST_WAIT) && expire && more_steps);
  assign load_val   = (state_q == ST_IDLE) ? CNT_W'(POWERUP_US) : CNT_W'(GUARD_US);

  ddr_init_tick_timer #(.CNT_W(CNT_W)) timer_i (
    .clk        (clk),
    .rst        (rst),
    .load_i     (load),
    .load_val_i (load_val),
    .tick_i     (us_tick_i),
    .expire_o   (expire)
  );

  ddr_init_mode_word #(.MODE_W(MODE_W), .BL_CODE(BL_CODE), .BT_BIT(BT_BIT)) mw_i (
    .cmd_i     (next_cmd),
    .dll_rst_i (step_q == STEP_W'(3)),
    .cas_i     (cas_q),
    .word_o    (next_word)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q      <= ST_IDLE;
      step_q       <= '0;
      cas_q        <= '0;
      cmd_stb_o    <= 1'b0;
      cmd_o        <= CMD_NOP;
      mode_word_o  <= '0;
      rx_resync_o  <= 1'b0;
      refresh_en_o <= 1'b0;
      done_o       <= 1'b0;
    end else begin
      cmd_stb_o   <= 1'b0;
      rx_resync_o <= 1'b0;
      case (state_q)
        ST_IDLE: if (start_i) begin
          cas_q   <= cas_sel_i;
          step_q  <= '0;
          state_q <= ST_WAIT;
        end
        ST_WAIT: if (expire) begin
          if (more_steps) begin
            cmd_stb_o   <= 1'b1;
            cmd_o       <= next_cmd;
            mode_word_o <= next_word;
            step_q      <= step_q + STEP_W'(1);
          end else begin
            rx_resync_o <= 1'b1;
            state_q     <= ST_SYNC;
          end
        end
        ST_SYNC: state_q <= ST_NORM;
        ST_NORM: begin
          cmd_stb_o   <= 1'b1;
          cmd_o       <= CMD_NORMAL;
          mode_word_o <= '0;
          state_q     <= ST_FIN;
        end
        ST_FIN: begin
          done_o       <= 1'b1;
          refresh_en_o <= 1'b1;
          state_q      <= ST_DONE;
        end
        default: state_q <= ST_DONE;
      endcase
    end
  end
endmodule

// File: rtl/ddr_init_seq_chk.sv
module ddr_init_seq_chk #(
  parameter int unsigned MODE_W = 13
) (
  input logic              clk,
  input logic              rst,
  input logic              cmd_stb_o,
  input logic [2:0]        cmd_o,
  input logic [MODE_W-1:0] mode_word_o,
  input logic              rx_resync_o,
  input logic              refresh_en_o,
  input logic              done_o
);
  // R2
  no_reserved_cmd_chk: assert property (@(posedge clk) disable iff (rst)
    cmd_stb_o |-> cmd_o != 3'b101);
  // R5
  cmd_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !cmd_stb_o |-> $stable(cmd_o));
  // R9
  resync_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    rx_resync_o |=> !rx_resync_o && !cmd_stb_o);
  // R9
  resync_before_done_chk: assert property (@(posedge clk) disable iff (rst)
    rx_resync_o |-> !done_o && !refresh_en_o);
  // R10
  done_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    done_o |=> done_o && refresh_en_o);
  // R10
  done_after_normal_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(done_o) |-> $past(cmd_stb_o) && $past(cmd_o) == 3'b111);
  // R12
  word_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd_stb_o && cmd_o != 3'b011) |-> mode_word_o == '0);
endmodule

bind ddr_init_seq ddr_init_seq_chk #(.MODE_W(MODE_W)) chk_i (
  .clk          (clk),
  .rst          (rst),
  .cmd_stb_o    (cmd_stb_o),
  .cmd_o        (cmd_o),
  .mode_word_o  (mode_word_o),
  .rx_resync_o  (rx_resync_o),
  .refresh_en_o (refresh_en_o),
  .done_o       (done_o)
);

// File: tb/ddr_init_seq_tb.sv
`timescale 1ns/1ps
module ddr_init_seq_tb_top;
  localparam int POW = 4;
  localparam int GRD = 3;
  localparam int NREF = 8;
  localparam int MW = 13;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic [2:0] cas_sel = 3'd2;
  logic tick = 1'b0;
  logic stb, resync, ref_en, done;
  logic [2:0] cmd;
  logic [MW-1:0] word;

  int n_tests = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  ddr_init_seq #(.POWERUP_US(POW), .GUARD_US(GRD), .NUM_REF(NREF), .MODE_W(MW)) dut_i (
    .clk(clk), .rst(rst), .start_i(start), .cas_sel_i(cas_sel), .us_tick_i(tick),
    .cmd_stb_o(stb), .cmd_o(cmd), .mode_word_o(word), .rx_resync_o(resync),
    .refresh_en_o(ref_en), .done_o(done));

  task automatic check(input string req, input logic ok, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int exp_cmd(input int s);
    if (s == 0) return 1;
    if (s == 1 || s == 4) return 2;
    if (s == 2) return 4;
    if (s == 3 || s == 5 + NREF) return 3;
    if (s < 5 + NREF) return 6;
    return 7;
  endfunction

  function automatic int exp_word(input int s, input int c);
    if (s == 3) return (2 << 7) | (c << 4) | (1 << 3) | 2;
    if (s == 5 + NREF) return (c << 4) | (1 << 3) | 2;
    return 0;
  endfunction

  task automatic run(input int c, input int per);
    int step, tcnt, cyc, rcyc, nref;
    logic fin;
    int last;
    rst = 1'b1; start = 1'b0; tick = 1'b0; cas_sel = 3'(c);
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1", !stb && !resync && !ref_en && !done && cmd == 3'b001 && word == '0,
          {stb, resync, ref_en, done, cmd}, 3'b001);
    rst = 1'b0;
    tick = 1'b1;
    repeat (2) @(negedge clk);
    // R1 idle: ticks alone start nothing
    check("R1", !stb && cmd == 3'b001 && !done, cmd, 1);
    tick = 1'b0; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    step = 0; tcnt = 0; cyc = 0; rcyc = -100; fin = 1'b0; last = 1; nref = 0;
    while (!fin && cyc < 3000) begin
      if (stb) begin
        if (step <= 5 + NREF) begin
          check("R2", int'(cmd) == exp_cmd(step), cmd, exp_cmd(step));
          check("R6/R7/R12", int'(word) == exp_word(step, c), word, exp_word(step, c));
          if (step == 0) check("R3", tcnt == POW, tcnt, POW);
          else check("R4", tcnt == GRD, tcnt, GRD);
          if (cmd == 3'b110) nref++;
        end else if (step == 6 + NREF) begin
          check("R2", cmd == 3'b111, cmd, 7);
          check("R9", cyc == rcyc + 2, cyc - rcyc, 2);
        end else check("R5", 1'b0, step, 6 + NREF);
        tcnt = 0;
        step++;
      end else begin
        check("R5", int'(cmd) == last, cmd, last);
      end
      last = int'(cmd);
      if (resync) begin
        check("R9", step == 6 + NREF && rcyc < 0, step, 6 + NREF);
        check("R4", tcnt == GRD, tcnt, GRD);
        check("R8", nref == NREF, nref, NREF);
        rcyc = cyc;
      end
      if (done) begin
        check("R10", step == 7 + NREF && cyc == rcyc + 3 && ref_en, cyc - rcyc, 3);
        fin = 1'b1;
      end else if (ref_en) check("R10", 1'b0, 1, 0);
      // R11: start and a new CAS code mid-run must be ignored
      start = (step == 6);
      cas_sel = (step >= 6) ? ~3'(c) : 3'(c);
      tick = ((cyc % per) == per - 1);
      if (tick) tcnt++;
      cyc++;
      @(negedge clk);
    end
    check("R10", fin, fin, 1);
    // R11/R10: start after done is ignored, flags stay
    start = 1'b1; tick = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int i = 0; i < 3 * POW + 3; i++) begin
      check("R11", !stb && done && ref_en && cmd == 3'b111, {stb, done, cmd}, 5'b01111);
      @(negedge clk);
    end
    tick = 1'b0;
  endtask

  initial begin
    #(200000 * 10);
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    run(2, 1);
    run(3, 2);
    run(5, 3);
    run(6, 5);
    run(6, 1);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule